// File: doc/BRIEF.md
# Serial Test-Pattern Receive Monitor

This block is the receive half of a bit error rate tester. It takes a serial bit stream with a per-cycle valid qualifier and first finds its place in a configured test pattern. The pattern is either a pseudo-random sequence that obeys x^n + x^y + 1, or a fixed word of n bits sent over and over. Once it holds sync, the block predicts every incoming bit from its own free-running state and counts an error for each bit that differs from the prediction. Sync holds even on a line whose error rate is about one in a thousand.

Two saturating counters run only while the block is in sync. One counts received bits and the other counts errored bits. A single latch strobe moves both counts into holding registers that drive the outputs, and it clears the live counters in the same cycle, so one snapshot always covers one measurement period. Software writes the pattern configuration with a load strobe. The strobe is honoured only while the monitor is enabled.

Top module: `bert_rx_mon`

## Requirements
- R1: In pseudo-random mode (`rep_mode_i`=0, length n from 2 to 32, tap y from 1 to n-1), the monitor fills its history with the first n valid bits. It predicts every later bit as the bit n places back XOR the bit y places back. `sync_o` rises on the cycle after the 32nd consecutive correct prediction, so a clean stream raises it after valid bit n+32 and not after bit n+31.
- R2: In repeat mode (`rep_mode_i`=1, length n from 1 to 32), the expected stream is `pat_i[0]`, `pat_i[1]` … `pat_i[n-1]` and then repeats. Hunting starts at pattern bit 0. Each mismatch moves the candidate alignment on by one rotation. 32 consecutive matches give sync, so a stream that starts at bit 0 locks after exactly 32 bits.
- R3: A misprediction before sync restarts the run of 32 matches. In pseudo-random mode, one corrupted bit k during the check phase delays sync until after bit k+n+32.
- R4: In sync, errors are tallied in consecutive blocks of 64 valid bits, and the first block starts with the first bit after sync. The sixth error inside one block drops `sync_o` on the next cycle. Five errors per block never drop sync, even when two blocks meet. After a loss the monitor hunts again (pseudo-random mode: fresh fill of n bits plus 32 matches).
- R5: Only while `sync_o` is high does each valid bit add one to the bit count, and each mispredicted bit add one to the error count. Bits that arrive while hunting change neither count.
- R6: The counts saturate at all ones: ERR_W bits for errors (default 24) and BIT_W bits for bits (default 32).
- R7: `latch_i` copies both live counts to `err_cnt_o`/`bit_cnt_o` on the next cycle and clears the live counts. A valid bit in the same cycle goes into the new period and not into the snapshot. A latch with no new bits in between yields zeros.
- R8: `load_i` takes the configuration and restarts the hunt only while `en_i` is high. With `en_i` low it is ignored. A valid bit in a load cycle is dropped.
- R9: With `en_i` low, `sync_o` falls on the next cycle and valid bits are ignored. Latching still works.
- R10: A pseudo-random stream with an error every 500 bits, starting during the fill, still reaches sync within 1000 bits.
- R11: After reset `sync_o`, `err_cnt_o` and `bit_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable |
| load_i | input | 1 | Configuration load strobe |
| rep_mode_i | input | 1 | 0 pseudo-random, 1 repeating word |
| len_i | input | 6 | Pattern length n |
| tap_i | input | 6 | Feedback tap y (pseudo-random mode) |
| pat_i | input | 32 | Repeat word, bit 0 sent first |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | Data bit qualifier |
| latch_i | input | 1 | Snapshot-and-clear strobe |
| sync_o | output | 1 | Pattern sync held |
| err_cnt_o | output | ERR_W | Latched error count |
| bit_cnt_o | output | BIT_W | Latched bit count |

## Verification
The snapshot strobe and the arrival of an errored, counted bit can fall in the same cycle. The bench provokes this by raising `latch_i` together with a valid corrupted bit while in sync. It then checks that the snapshot holds only the earlier period and that the next snapshot shows exactly one bit and one error. Loss of sync and counting also meet on one bit, because the sixth error in a block is still counted. The bench confirms this from the following snapshot.

// File: rtl/bert_pkg.sv
package bert_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } mon_st_e;
endpackage

// File: rtl/bert_pred.sv
module bert_pred #(
  parameter int MAX_LEN = 32,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int PW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               lock_i,
  input  logic               skip_i,
  input  logic               zero_ptr_i,
  input  logic               rep_i,
  input  logic [LW-1:0]      len_i,
  input  logic [LW-1:0]      tap_i,
  input  logic [MAX_LEN-1:0] pat_i,
  input  logic               bit_i,
  output logic               pred_o
);
  logic [MAX_LEN-1:0] hist_q;
  logic [PW-1:0]      ptr_q;
  logic [PW-1:0]      n_idx, y_idx;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p, input logic [LW-1:0] n);
    if (int'(p) + 1 >= int'(n)) return '0;
    return p + 1'b1;
  endfunction

  assign n_idx  = (len_i == '0) ? '0 : PW'(len_i - 1'b1);
  assign y_idx  = (tap_i == '0) ? '0 : PW'(tap_i - 1'b1);
  assign pred_o = rep_i ? pat_i[ptr_q] : (hist_q[n_idx] ^ hist_q[y_idx]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (zero_ptr_i) ptr_q <= '0;
      else if (step_i && rep_i)
        ptr_q <= skip_i ? wrap_inc(wrap_inc(ptr_q, len_i), len_i) : wrap_inc(ptr_q, len_i);
      // in lock the history runs on its own prediction so line errors do not spread
      if (step_i) hist_q <= {hist_q[MAX_LEN-2:0], lock_i ? pred_o : bit_i};
    end
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_i && len_i != '0) |-> (int'(ptr_q) < int'(len_i)));
endmodule

// File: rtl/bert_sync.sv
module bert_sync
  import bert_pkg::*;
#(
  parameter int MAX_LEN   = 32,
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int RW = $clog2(SYNC_RUN),
  localparam int WW = $clog2(WIN_LEN),
  localparam int EW = $clog2(LOSS_ERRS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic          hunt_rep_i,
  input  logic [LW-1:0] len_i,
  input  logic          bit_i,
  input  logic          pred_i,
  output logic          lock_o,
  output logic          skip_o,
  output logic          err_o
);
  mon_st_e       st_q, hunt_st;
  logic [LW-1:0] fill_q;
  logic [RW-1:0] run_q;
  logic [WW-1:0] win_pos_q;
  logic [EW-1:0] win_err_q, win_tot;
  logic          miss;

  assign miss    = bit_i ^ pred_i;
  assign hunt_st = hunt_rep_i ? ST_CHECK : ST_FILL;
  assign lock_o  = (st_q == ST_LOCK);
  assign skip_o  = step_i && (st_q == ST_CHECK) && miss;
  assign err_o   = step_i && (st_q == ST_LOCK) && miss;
  assign win_tot = win_err_q + EW'(miss);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_FILL;
      fill_q    <= '0;
      run_q     <= '0;
      win_pos_q <= '0;
      win_err_q <= '0;
    end else if (restart_i) begin
      st_q   <= hunt_st;
      fill_q <= '0;
      run_q  <= '0;
    end else if (step_i) begin
      unique case (st_q)
        ST_FILL: begin
          if (int'(fill_q) + 1 >= int'(len_i)) begin
            st_q  <= ST_CHECK;
            run_q <= '0;
          end else fill_q <= fill_q + 1'b1;
        end
        ST_CHECK: begin
          if (miss) run_q <= '0;
          else if (int'(run_q) == SYNC_RUN - 1) begin
            st_q      <= ST_LOCK;
            win_pos_q <= '0;
            win_err_q <= '0;
          end else run_q <= run_q + 1'b1;
        end
        ST_LOCK: begin
          if (int'(win_tot) >= LOSS_ERRS) begin
            st_q   <= hunt_st;
            fill_q <= '0;
            run_q  <= '0;
          end else if (int'(win_pos_q) == WIN_LEN - 1) begin
            win_pos_q <= '0;
            win_err_q <= '0;
          end else begin
            win_pos_q <= win_pos_q + 1'b1;
            win_err_q <= win_tot;
          end
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end

  // R1
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(st_q) == ST_CHECK) && $past(step_i) && !$past(skip_o));
  // R4
  win_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (int'(win_err_q) < LOSS_ERRS));
  // R9
  restart_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !lock_o);
  // R3
  check_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && !restart_i) |=> (st_q == ST_CHECK) && (run_q == '0));
endmodule

// File: rtl/bert_cnt.sv
module bert_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] held_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      held_o <= '0;
    end else if (clr_i) begin
      held_o <= live_q;
      live_q <= W'(inc_i);
    end else if (inc_i && live_q != CNT_MAX) begin
      live_q <= live_q + 1'b1;
    end
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == CNT_MAX && !clr_i) |=> live_q == CNT_MAX);
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> live_q <= W'(1));
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(live_q) && $stable(held_o));
endmodule

// File: rtl/bert_rx_mon.sv
module bert_rx_mon #(
  parameter int MAX_LEN   = 32,
  parameter int ERR_W     = 24,
  parameter int BIT_W     = 32,
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               load_i,
  input  logic               rep_mode_i,
  input  logic [LW-1:0]      len_i,
  input  logic [LW-1:0]      tap_i,
  input  logic [MAX_LEN-1:0] pat_i,
  input  logic               bit_i,
  input  logic               bit_vld_i,
  input  logic               latch_i,
  output logic               sync_o,
  output logic [ERR_W-1:0]   err_cnt_o,
  output logic [BIT_W-1:0]   bit_cnt_o
);
  logic               cfg_rep_q;
  logic [LW-1:0]      cfg_len_q, cfg_tap_q;
  logic [MAX_LEN-1:0] cfg_pat_q;
  logic load_ok, step, restart, hunt_rep, pred, skip, err, lock;

  assign load_ok  = load_i & en_i;
  assign step     = bit_vld_i & en_i & ~load_i;
  assign restart  = load_ok | ~en_i;
  assign hunt_rep = load_ok ? rep_mode_i : cfg_rep_q;
  assign sync_o   = lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rep_q <= 1'b0;
      cfg_len_q <= LW'(7);
      cfg_tap_q <= LW'(6);
      cfg_pat_q <= '0;
    end else if (load_ok) begin
      cfg_rep_q <= rep_mode_i;
      cfg_len_q <= len_i;
      cfg_tap_q <= tap_i;
      cfg_pat_q <= pat_i;
    end
  end

  bert_pred #(.MAX_LEN(MAX_LEN)) u_pred (
    .clk_i, .rst_ni,
    .step_i(step), .lock_i(lock), .skip_i(skip), .zero_ptr_i(load_ok),
    .rep_i(cfg_rep_q), .len_i(cfg_len_q), .tap_i(cfg_tap_q), .pat_i(cfg_pat_q),
    .bit_i, .pred_o(pred)
  );

  bert_sync #(
    .MAX_LEN(MAX_LEN), .SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .LOSS_ERRS(LOSS_ERRS)
  ) u_sync (
    .clk_i, .rst_ni,
    .step_i(step), .restart_i(restart), .hunt_rep_i(hunt_rep), .len_i(cfg_len_q),
    .bit_i, .pred_i(pred), .lock_o(lock), .skip_o(skip), .err_o(err)
  );

  bert_cnt #(.W(ERR_W)) u_err_cnt (
    .clk_i, .rst_ni, .inc_i(err), .clr_i(latch_i), .held_o(err_cnt_o)
  );

  bert_cnt #(.W(BIT_W)) u_bit_cnt (
    .clk_i, .rst_ni, .inc_i(step & lock), .clr_i(latch_i), .held_o(bit_cnt_o)
  );

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cfg_rep_q) && $stable(cfg_len_q) && $stable(cfg_tap_q) && $stable(cfg_pat_q));
  // R5
  err_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> sync_o && bit_vld_i);
endmodule

// File: tb/bert_rx_mon_tb_top.sv
module bert_rx_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 4;
  localparam int BIT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, load_i = 1'b0, rep_mode_i = 1'b0;
  logic [5:0] len_i = '0, tap_i = '0;
  logic [31:0] pat_i = '0;
  logic bit_i = 1'b0, bit_vld_i = 1'b0, latch_i = 1'b0;
  logic sync_o;
  logic [ERR_W-1:0] err_cnt_o;
  logic [BIT_W-1:0] bit_cnt_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] g, rpat;
  int gn, gy, rn, ridx;

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_rx_mon #(.ERR_W(ERR_W), .BIT_W(BIT_W)) dut_i (
    .clk_i(clk), .rst_ni, .en_i, .load_i, .rep_mode_i, .len_i, .tap_i, .pat_i,
    .bit_i, .bit_vld_i, .latch_i, .sync_o, .err_cnt_o, .bit_cnt_o
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic v, input logic l);
    bit_i = b; bit_vld_i = v; latch_i = l;
    @(negedge clk);
    bit_vld_i = 1'b0; latch_i = 1'b0;
  endtask

  task automatic do_load(input logic rep, input int n, input int y, input logic [31:0] p);
    rep_mode_i = rep; len_i = 6'(n); tap_i = 6'(y); pat_i = p; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic prbs_cfg(input int n, input int y);
    gn = n; gy = y; g = 32'h1;
    do_load(1'b0, n, y, 32'h0);
  endtask

  task automatic gen_prbs(input logic e);
    logic nb;
    nb = g[gn-1] ^ g[gy-1];
    g = {g[30:0], nb};
    cyc(nb ^ e, 1'b1, 1'b0);
  endtask

  task automatic gen_rep(input logic e);
    cyc(rpat[ridx] ^ e, 1'b1, 1'b0);
    ridx = (ridx + 1) % rn;
  endtask

  task automatic snap(input string tag, input int eb, input int ee);
    cyc(1'b0, 1'b0, 1'b1);
    check({tag, " bits"}, bit_cnt_o, eb);
    check({tag, " errs"}, err_cnt_o, ee);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int nl[9] = '{3, 5, 7, 9, 11, 15, 20, 23, 31};
    int yl[9] = '{2, 3, 6, 5, 9, 14, 17, 18, 28};
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 sync", sync_o, 0);
    check("R11 errs", err_cnt_o, 0);
    check("R11 bits", bit_cnt_o, 0);
    rst_ni = 1'b1; en_i = 1'b1;
    @(negedge clk);

    // R1 lock timing over a sweep of polynomials, R5 counting
    for (int i = 0; i < 9; i++) begin
      prbs_cfg(nl[i], yl[i]);
      check("R8 load restarts hunt", sync_o, 0);
      for (int k = 0; k < nl[i] + 31; k++) gen_prbs(1'b0);
      check("R1 no sync at n+31", sync_o, 0);
      gen_prbs(1'b0);
      check("R1 sync at n+32", sync_o, 1);
      for (int k = 0; k < 40; k++) gen_prbs(1'b0);
      snap("R5 clean run", 40, 0);
    end

    // R3 one corrupted bit during the check phase (n=7, y=6, k=17)
    prbs_cfg(7, 6);
    for (int k = 1; k < 17; k++) gen_prbs(1'b0);
    gen_prbs(1'b1);
    for (int k = 18; k <= 17 + 7 + 31; k++) gen_prbs(1'b0);
    check("R3 no sync at k+n+31", sync_o, 0);
    gen_prbs(1'b0);
    check("R3 sync at k+n+32", sync_o, 1);

    // R4 windows, R5 counts, R6 saturation
    prbs_cfg(11, 9);
    for (int k = 0; k < 11 + 32; k++) gen_prbs(1'b0);
    check("R1 lock n=11", sync_o, 1);
    for (int p = 0; p < 64; p++) gen_prbs(p >= 59);
    for (int p = 0; p < 64; p++) gen_prbs(p < 5);
    check("R4 five per block keeps sync", sync_o, 1);
    snap("R5 errored run", 128, 10);
    for (int p = 0; p < 5; p++) gen_prbs(1'b1);
    check("R4 five in block", sync_o, 1);
    gen_prbs(1'b1);
    check("R4 sixth in block drops", sync_o, 0);
    snap("R5 loss bit counted", 6, 6);
    for (int k = 0; k < 11 + 31; k++) gen_prbs(1'b0);
    check("R4 relock pending", sync_o, 0);
    gen_prbs(1'b0);
    check("R4 relock after fill", sync_o, 1);
    snap("R5 hunt not counted", 0, 0);
    for (int w = 0; w < 4; w++)
      for (int p = 0; p < 64; p++) gen_prbs(p < 5);
    check("R6 sync kept", sync_o, 1);
    snap("R6 saturate", 255, 15);
    snap("R7 cleared", 0, 0);

    // R7 latch meets an errored bit in the same cycle
    for (int k = 0; k < 10; k++) gen_prbs(1'b0);
    begin
      logic nb;
      nb = g[gn-1] ^ g[gy-1];
      g = {g[30:0], nb};
      cyc(~nb, 1'b1, 1'b1);
    end
    check("R7 snapshot bits", bit_cnt_o, 10);
    check("R7 snapshot errs", err_cnt_o, 0);
    snap("R7 same-cycle bit in new period", 1, 1);

    // R9 disable, R8 load ignored while disabled
    en_i = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    check("R9 sync drops", sync_o, 0);
    for (int k = 0; k < 20; k++) gen_prbs(1'b0);
    do_load(1'b1, 4, 1, 32'h5);
    check("R9 no sync while off", sync_o, 0);
    snap("R9 bits ignored", 0, 0);
    en_i = 1'b1;
    for (int k = 0; k < 11 + 31; k++) gen_prbs(1'b0);
    check("R8 old config pending", sync_o, 0);
    gen_prbs(1'b0);
    check("R8 old config kept", sync_o, 1);

    // R2 repeating words from bit 0
    begin
      int rl[5] = '{8, 1, 5, 32, 13};
      logic [31:0] pl[5] = '{32'hB4, 32'h1, 32'h13, 32'hDEADBEEF, 32'h1A2B};
      for (int i = 0; i < 5; i++) begin
        rn = rl[i]; rpat = pl[i]; ridx = 0;
        do_load(1'b1, rn, 0, rpat);
        for (int k = 0; k < 31; k++) gen_rep(1'b0);
        check("R2 no sync at 31", sync_o, 0);
        gen_rep(1'b0);
        check("R2 sync at 32", sync_o, 1);
        for (int k = 0; k < 64; k++) gen_rep(k == 10);
        snap("R2 repeat count", 64, 1);
      end
    end

    // R2 rotation search from an offset start
    begin
      int seen = 0;
      rn = 8; rpat = 32'hB4; ridx = 3;
      do_load(1'b1, rn, 0, rpat);
      for (int k = 0; k < 400 && seen == 0; k++) begin
        gen_rep(1'b0);
        if (sync_o) seen = 1;
      end
      check("R2 offset alignment", seen, 1);
      snap("R2 offset clear", 0, 0);
      for (int k = 0; k < 50; k++) gen_rep(1'b0);
      snap("R2 offset count", 50, 0);
    end

    // R10 sync with sparse errors
    begin
      int at = 0;
      prbs_cfg(15, 14);
      for (int k = 1; k <= 2000; k++) begin
        gen_prbs((k % 500) == 3);
        if (sync_o && at == 0) at = k;
      end
      check("R10 locked", (at > 0 && at <= 1000) ? 1 : 0, 1);
      check("R10 held", sync_o, 1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule